// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block collects the interrupt events of a CAN controller core into one CPU-readable byte and raises a single interrupt request while any flag in it is set. There are five flags: receive message available, transmit buffer released, error or bus status changed, receive overrun, and wake-up. Each flag has its own set rule. Wake-up is always armed. The other four are gated by enable inputs that come from the controller's control register.

The CPU cannot write the register. Reading it returns the current flags, and all flags clear together at the end of the read cycle. An event that arrives in the same cycle as the read is not lost: it is set after the read. Level status inputs are compared against copies taken at each clock edge. The async active-low reset clears those copies to zero.

Top module: `can_irq_reg`

## Requirements
- R1: `rdata_o` bit 0 is receive, bit 1 is transmit, bit 2 is error, bit 3 is overrun and bit 4 is wake-up; bits 7 to 5 always read 0.
- R2: `irq_o` is high exactly when at least one of the five flags is set.
- R3: `rdata_o` shows the flags during a cycle with `rd_i` high. At the clock edge that ends that cycle all flags clear. Without a read, a set flag stays set.
- R4: the wake-up flag sets at the edge where `wake_exit_i` is high, with no enable.
- R5: the overrun flag sets at an edge where `store_first_i`, `rx_full_i` and `ovr_ie_i` are all high. If any one of them is low, it does not set.
- R6: the error flag sets at an edge where `err_stat_i` or `bus_stat_i` differs from its value at the previous edge, provided `err_ie_i` is high. A rise and a fall both count.
- R7: the transmit flag sets at an edge where `tx_access_i` is high and was low at the previous edge, provided `tx_ie_i` is high. A fall or a steady level does nothing.
- R8: the receive flag sets at an edge where `rx_new_i` is high and `rx_ie_i` is high.
- R9: a set condition present in the same cycle as a read leaves its flag set after that read.
- R10: reset clears all flags and the stored previous values of `err_stat_i`, `bus_stat_i` and `tx_access_i` to 0. A status input held high through reset therefore counts as a change at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rx_new_i | input | 1 | new message available in the receive buffer |
| tx_access_i | input | 1 | transmit buffer access status (1 = released) |
| err_stat_i | input | 1 | error status level |
| bus_stat_i | input | 1 | bus status level |
| rx_full_i | input | 1 | both receive buffers hold a message |
| store_first_i | input | 1 | first byte of an accepted message is being stored |
| wake_exit_i | input | 1 | controller is leaving sleep mode |
| rx_ie_i | input | 1 | receive interrupt enable |
| tx_ie_i | input | 1 | transmit interrupt enable |
| err_ie_i | input | 1 | error interrupt enable |
| ovr_ie_i | input | 1 | overrun interrupt enable |
| rd_i | input | 1 | CPU read strobe for this register |
| rdata_o | output | 8 | register read data |
| irq_o | output | 1 | interrupt request to the CPU |

## Verification
Faults in the flag register show up on `irq_o` and `rdata_o` one edge after the event or read that exposes them. Faults in the stored previous status values stay hidden until the status input next holds steady or toggles. At that point a spurious or missing error or transmit flag appears one edge later. The stimulus therefore holds status levels across reads, to expose stale copies. It also includes a reset with a status input held high, to expose copies that reset to the wrong value.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned RX_BIT    = 0;
  localparam int unsigned TX_BIT    = 1;
  localparam int unsigned ERR_BIT   = 2;
  localparam int unsigned OVR_BIT   = 3;
  localparam int unsigned WAKE_BIT  = 4;
  localparam int unsigned RSV_W     = REG_W - NUM_FLAGS;
endpackage

// File: rtl/can_irq_chg.sv
module can_irq_chg #(
  parameter int unsigned W         = 1,
  parameter bit          RISE_ONLY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic         hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  generate
    if (RISE_ONLY) begin : g_rise
      assign hit_o = |(sig_i & ~prev_q);
    end else begin : g_any
      assign hit_o = |(sig_i ^ prev_q);
    end
  endgenerate
endmodule

// File: rtl/can_irq_flag.sv
module can_irq_flag #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[k] <= 1'b0;
      else         flag_o[k] <= (flag_o[k] & ~clr_i) | set_i[k]; // set wins over clear
    end

    p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[k] && !clr_i) |=> flag_o[k]);
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
  end
endmodule

// File: rtl/can_irq_reg.sv
module can_irq_reg
  import can_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_new_i,
  input  logic             tx_access_i,
  input  logic             err_stat_i,
  input  logic             bus_stat_i,
  input  logic             rx_full_i,
  input  logic             store_first_i,
  input  logic             wake_exit_i,
  input  logic             rx_ie_i,
  input  logic             tx_ie_i,
  input  logic             err_ie_i,
  input  logic             ovr_ie_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic                 tx_rise;
  logic                 stat_chg;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;

  can_irq_chg #(.W(1), .RISE_ONLY(1'b1)) i_tx_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (tx_access_i),
    .hit_o (tx_rise)
  );

  can_irq_chg #(.W(2), .RISE_ONLY(1'b0)) i_stat_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({bus_stat_i, err_stat_i}),
    .hit_o (stat_chg)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[RX_BIT]   = rx_new_i & rx_ie_i;
    set_vec[TX_BIT]   = tx_rise & tx_ie_i;
    set_vec[ERR_BIT]  = stat_chg & err_ie_i;
    set_vec[OVR_BIT]  = store_first_i & rx_full_i & ovr_ie_i;
    set_vec[WAKE_BIT] = wake_exit_i;
  end

  can_irq_flag #(.N(NUM_FLAGS)) i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (rd_i),
    .flag_o(flags)
  );

  assign rdata_o = {{RSV_W{1'b0}}, flags};
  assign irq_o   = |flags;

  p_clear_on_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set_vec == '0) |=> (rdata_o == '0 && !irq_o));
  p_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_exit_i |=> rdata_o[WAKE_BIT]);
  p_tx_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_access_i) && tx_ie_i) |=> rdata_o[TX_BIT]);
  p_err_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_stat_i != $past(err_stat_i) || bus_stat_i != $past(bus_stat_i)) && err_ie_i)
      |=> rdata_o[ERR_BIT]);
  p_ovr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_first_i && rx_full_i && ovr_ie_i) |=> rdata_o[OVR_BIT]);
  p_reserved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> rdata_o[REG_W-1:NUM_FLAGS] == '0);
endmodule

// File: tb/test_can_irq_reg.sv
`timescale 1ns/1ps
module test_can_irq_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_new = 0, tx_acc = 0, err_s = 0, bus_s = 0, rx_full = 0, store = 0, wake = 0;
  logic rx_ie = 0, tx_ie = 0, err_ie = 0, ovr_ie = 0, rd = 0;
  logic [7:0] rdata;
  logic irq;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  can_irq_reg i_can_irq_reg (
    .clk_i(clk), .rst_ni(rst_n), .rx_new_i(rx_new), .tx_access_i(tx_acc),
    .err_stat_i(err_s), .bus_stat_i(bus_s), .rx_full_i(rx_full),
    .store_first_i(store), .wake_exit_i(wake), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .err_ie_i(err_ie), .ovr_ie_i(ovr_ie), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  // row: rd | ie{ovr,err,tx,rx} | wake,full,store,rxnew | err,bus,txa | expected flags
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    20'b0_1111_0001_000_00000001, // R8 receive
    20'b1_1111_0000_000_00000000, // R3 clear
    20'b0_1111_0000_001_00000010, // R7 rise
    20'b1_1111_0000_001_00000000, // R7 steady high
    20'b0_1111_0000_000_00000000, // R7 fall ignored
    20'b0_1111_0000_100_00000100, // R6 error rise
    20'b1_1111_0000_100_00000000, // R6 steady
    20'b1_1111_0000_000_00000100, // R9 fall during read
    20'b1_1111_0000_000_00000000, // R3
    20'b0_1011_0000_010_00000000, // R6 disabled
    20'b0_1111_0010_010_00000000, // R5 not full
    20'b0_0111_0110_010_00000000, // R5 disabled
    20'b0_1111_0110_010_00001000, // R5 overrun
    20'b0_0000_1000_010_00011000, // R4 wake no enable
    20'b0_1110_0001_010_00011000, // R8 disabled
    20'b1_1111_0000_000_00000100, // R9 bus fall during read
    20'b1_1111_0000_000_00000000  // R3
  };

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s rdata=%h expected=%h", req, rdata, exp);
    end
    total++;
    if (irq !== (exp != 8'h00)) begin
      bad++;
      $display("FAIL R2 irq=%b expected=%b", irq, exp != 8'h00);
    end
  endtask

  task automatic idle();
    rd = 0; rx_new = 0; store = 0; rx_full = 0; wake = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R10 after release", 8'h00);

    for (int i = 0; i < NV; i++) begin
      {rd, ovr_ie, err_ie, tx_ie, rx_ie, wake, rx_full, store, rx_new,
       err_s, bus_s, tx_acc} = VEC[i][19:8];
      @(negedge clk);
      check($sformatf("R1 vector %0d", i), VEC[i][7:0]);
    end

    // read data visible during read cycle
    idle(); rx_ie = 1; tx_ie = 1; err_ie = 1; ovr_ie = 1;
    rx_new = 1;
    @(negedge clk);
    rx_new = 0; wake = 1;
    @(negedge clk);
    wake = 0; rd = 1;
    #1 check("R3 data during read", 8'h11);
    @(negedge clk);
    rd = 0;
    check("R3 cleared after read", 8'h00);
    @(negedge clk);
    check("R3 stays clear", 8'h00);

    // set during read, receive flag
    rx_new = 1; rd = 1;
    @(negedge clk);
    idle();
    check("R9 receive during read", 8'h01);

    // reset with status held high
    err_s = 1; tx_acc = 1; tx_ie = 0;
    @(negedge clk);
    rst_n = 0;
    #1 check("R10 async clear", 8'h00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 prev cleared", 8'h04);
    rd = 1;
    @(negedge clk);
    rd = 0;
    check("R6 steady after read", 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule